// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with Two Routed Outputs

This block gathers a vector of level-sensitive interrupt request lines, brings them into the local clock domain, and presents them to a processor through a small 32-bit register window. Each request line has its own enable bit. The topmost enable bit also serves as a master switch: when it is clear, nothing reaches either interrupt line. Software never writes the enable word directly. It sets bits through one address and clears them through another, so two agents can change the enables without a read-modify-write race.

A routing word decides, for each source, which of two processor interrupt lines it drives. Each line has a masked status word that software reads to find out who is asking. An unmasked raw view of the synchronized inputs is also readable. For convenience, a priority encoder reports the lowest-numbered active source on line 0, with a valid flag. Nothing is latched: a status bit follows its input level, so a request is dropped at its source.

Top module: `lvl_intc`

## Requirements
- R1: After reset the enable word and the routing word are both zero. Both interrupt lines are low and the encoder valid flag is low.
- R2: A write to offset 0x34 sets every enable bit whose data bit is 1 and leaves the other enable bits unchanged. A read of 0x34 returns the enable word.
- R3: A write to offset 0x38 clears every enable bit whose data bit is 1. Writing all ones clears the whole enable word, bit 31 included.
- R4: While enable bit 31 (the master enable) is 0, both masked status words read zero and both interrupt lines stay low, whatever the inputs.
- R5: A routing bit of 0 at offset 0x20 sends that source to status word 0 (offset 0x00) and line 0. A routing bit of 1 sends it to status word 1 (offset 0x04) and line 1. The routing word reads back at 0x20.
- R6: The raw status word at offset 0x30 shows each source input two clock edges after it changes, whatever the enable and routing settings.
- R7: Status bits are level-true. When an enabled source input drops, its status bit clears two edges later, and nothing holds it.
- R8: Each interrupt line is the OR of its masked status word, registered, so it changes one edge after that status word.
- R9: Writes to offsets 0x00, 0x04 and 0x30 change neither the enable word nor the routing word.
- R10: The encoder index gives the lowest set bit of status word 0. Its valid flag is high exactly when status word 0 is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_i | input | 32 | Level interrupt request inputs, asynchronous |
| irq0_o | output | 1 | Processor interrupt line 0 |
| irq1_o | output | 1 | Processor interrupt line 1 |
| first_idx_o | output | 5 | Lowest active source index on line 0 |
| first_vld_o | output | 1 | High when any source is active on line 0 |

## Verification
A change on a source input reaches the raw and masked status words, and the encoder, after two rising edges. It reaches the interrupt lines after three. A register write changes the status words at the edge that takes it, and the lines one edge later. The bench drives every input on a falling edge and reads at the falling edge where the result is due. In one targeted case it also samples one falling edge earlier, to confirm that a line has not yet moved. Sweeps walk each source through the raw, routed and encoded paths and compare against words computed in the bench.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_STAT0 = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT1 = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 8'h38;
endpackage

// File: rtl/lvl_intc_sync.sv
module lvl_intc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar s;
  for (s = 0; s < STAGES; s++) begin : g_stg
    logic [W-1:0] nxt;
    logic [W-1:0] flop_q;
    if (s == 0) begin : g_head
      assign nxt = d;
    end else begin : g_tail
      assign nxt = g_stg[s-1].flop_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flop_q <= '0;
      else        flop_q <= nxt;
    end
  end

  assign q = g_stg[STAGES-1].flop_q;
endmodule

// File: rtl/lvl_intc_regs.sv
module lvl_intc_regs
  import lvl_intc_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N_SRC-1:0]  bus_wdata,
  input  logic [N_SRC-1:0]  stat0,
  input  logic [N_SRC-1:0]  stat1,
  input  logic [N_SRC-1:0]  raw,
  output logic [N_SRC-1:0]  en_q,
  output logic [N_SRC-1:0]  route_q,
  output logic [N_SRC-1:0]  rdata
);
  logic [N_SRC-1:0] en_d, route_d;
  logic             en_ce, route_ce;

  always_comb begin
    en_d     = en_q;
    route_d  = route_q;
    en_ce    = 1'b0;
    route_ce = 1'b0;
    if (bus_we) begin
      unique case (bus_addr)
        OFS_ENSET: begin en_d = en_q | bus_wdata;  en_ce = 1'b1; end
        OFS_ENCLR: begin en_d = en_q & ~bus_wdata; en_ce = 1'b1; end
        OFS_ROUTE: begin route_d = bus_wdata;      route_ce = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        route_q <= '0;
    else if (route_ce) route_q <= route_d;
  end

  always_comb begin
    unique case (bus_addr)
      OFS_STAT0: rdata = stat0;
      OFS_STAT1: rdata = stat1;
      OFS_ROUTE: rdata = route_q;
      OFS_RAW:   rdata = raw;
      OFS_ENSET: rdata = en_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/lvl_intc_route.sv
module lvl_intc_route #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] raw,
  input  logic [N_SRC-1:0] en_q,
  input  logic [N_SRC-1:0] route_q,
  output logic [N_SRC-1:0] stat0,
  output logic [N_SRC-1:0] stat1,
  output logic             irq0_q,
  output logic             irq1_q
);
  localparam int unsigned MASTER_BIT = N_SRC - 1;

  logic [N_SRC-1:0] gated;
  logic             irq0_d, irq1_d;

  always_comb begin
    gated  = raw & en_q & {N_SRC{en_q[MASTER_BIT]}};
    stat0  = gated & ~route_q;
    stat1  = gated & route_q;
    irq0_d = |stat0;
    irq1_d = |stat1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
    end else begin
      irq0_q <= irq0_d;
      irq1_q <= irq1_d;
    end
  end
endmodule

// File: rtl/lvl_intc_prienc.sv
module lvl_intc_prienc #(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             vld
);
  always_comb begin
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    vld = |vec;
  end
endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
  import lvl_intc_pkg::*;
#(
  parameter int unsigned N_SRC       = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  src_i,
  output logic              irq0_o,
  output logic              irq1_o,
  output logic [IDX_W-1:0]  first_idx_o,
  output logic              first_vld_o
);
  logic             rst_ns;
  logic [N_SRC-1:0] raw, en_q, route_q, stat0, stat1;

  lvl_intc_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ns)
  );

  lvl_intc_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_src_sync (
    .clk(clk), .rst_n(rst_ns), .d(src_i), .q(raw)
  );

  lvl_intc_regs #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_ns), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .stat0(stat0), .stat1(stat1), .raw(raw),
    .en_q(en_q), .route_q(route_q), .rdata(bus_rdata)
  );

  lvl_intc_route #(.N_SRC(N_SRC)) u_route (
    .clk(clk), .rst_n(rst_ns), .raw(raw), .en_q(en_q), .route_q(route_q),
    .stat0(stat0), .stat1(stat1), .irq0_q(irq0_o), .irq1_q(irq1_o)
  );

  lvl_intc_prienc #(.N_SRC(N_SRC)) u_enc (
    .vec(stat0), .idx(first_idx_o), .vld(first_vld_o)
  );
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk
  import lvl_intc_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input logic              clk,
  input logic              rst_ns,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [N_SRC-1:0]  bus_wdata,
  input logic [N_SRC-1:0]  en_q,
  input logic [N_SRC-1:0]  route_q,
  input logic [N_SRC-1:0]  stat0,
  input logic [N_SRC-1:0]  stat1,
  input logic              irq0_o,
  input logic              irq1_o,
  input logic [IDX_W-1:0]  first_idx_o,
  input logic              first_vld_o
);
  // R2
  enset_sticks_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_we && bus_addr == OFS_ENSET) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R3
  enclr_all_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_we && bus_addr == OFS_ENCLR && (&bus_wdata)) |=> (en_q == '0));

  // R4
  master_off_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!en_q[N_SRC-1]) |-> (stat0 == '0 && stat1 == '0));

  // R5
  route_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (stat0 & stat1) == '0);

  // R8
  irq0_follow_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    irq0_o == $past(|stat0));

  // R8
  irq1_follow_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    irq1_o == $past(|stat1));

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_we && (bus_addr == OFS_STAT0 || bus_addr == OFS_STAT1 || bus_addr == OFS_RAW))
    |=> ($stable(en_q) && $stable(route_q)));

  // R10
  enc_hit_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    first_vld_o |-> (stat0[first_idx_o] && ((stat0 & ((N_SRC'(1) << first_idx_o) - N_SRC'(1))) == '0)));

  // R10
  enc_vld_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    first_vld_o == (stat0 != '0));
endmodule

bind lvl_intc lvl_intc_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .en_q(en_q), .route_q(route_q), .stat0(stat0),
  .stat1(stat1), .irq0_o(irq0_o), .irq1_o(irq1_o),
  .first_idx_o(first_idx_o), .first_vld_o(first_vld_o)
);

// File: tb/sim_lvl_intc.sv
`timescale 1ns/1ps
module sim_lvl_intc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] src_i;
  logic        irq0_o, irq1_o;
  logic [4:0]  first_idx_o;
  logic        first_vld_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] m_en, m_rt;

  always #2.5 clk = ~clk;

  lvl_intc u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i),
    .irq0_o(irq0_o), .irq1_o(irq1_o), .first_idx_o(first_idx_o),
    .first_vld_o(first_vld_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_s0(input logic [31:0] s);
    return s & m_en & ~m_rt & {32{m_en[31]}};
  endfunction
  function automatic logic [31:0] exp_s1(input logic [31:0] s);
    return s & m_en & m_rt & {32{m_en[31]}};
  endfunction
  function automatic logic [31:0] low_idx(input logic [31:0] v);
    logic [31:0] r = 32'd0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = 32'(i);
    return r;
  endfunction

  task automatic check_all(input string req);
    logic [31:0] v, e0, e1;
    e0 = exp_s0(src_i);
    e1 = exp_s1(src_i);
    rd(8'h30, v); check({req, " raw"}, v, src_i);
    rd(8'h00, v); check({req, " stat0"}, v, e0);
    rd(8'h04, v); check({req, " stat1"}, v, e1);
    check({req, " irq0"}, {31'd0, irq0_o}, {31'd0, |e0});
    check({req, " irq1"}, {31'd0, irq1_o}, {31'd0, |e1});
    check({req, " vld"}, {31'd0, first_vld_o}, {31'd0, |e0});
    if (|e0) check({req, " idx"}, {27'd0, first_idx_o}, low_idx(e0));
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = 8'h00; bus_we = 1'b0; bus_wdata = '0; src_i = '0;
    m_en = '0; m_rt = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h34, v); check("R1 enable", v, 32'h0);
    rd(8'h20, v); check("R1 route", v, 32'h0);
    check("R1 irq", {30'd0, irq1_o, irq0_o}, 32'h0);
    check("R1 vld", {31'd0, first_vld_o}, 32'h0);

    // R6 raw sweep with everything disabled
    for (int i = 0; i < 32; i++) begin
      src_i = 32'h1 << i;
      repeat (2) @(negedge clk);
      check_all("R6");
    end

    // R2 set with pattern, then a zero write
    wr(8'h34, 32'h0000_00FF); m_en |= 32'h0000_00FF;
    rd(8'h34, v); check("R2 set", v, m_en);
    wr(8'h34, 32'h0); rd(8'h34, v); check("R2 zero write", v, m_en);
    wr(8'h34, 32'hFFFF_FFFF); m_en = '1;
    rd(8'h34, v); check("R2 all", v, m_en);

    // R5 routing sweeps over several route words
    for (int r = 0; r < 3; r++) begin
      logic [31:0] rt;
      rt = (r == 0) ? 32'h0 : (r == 1) ? 32'hAAAA_5555 : 32'hFFFF_0000;
      wr(8'h20, rt); m_rt = rt;
      rd(8'h20, v); check("R5 route readback", v, rt);
      for (int i = 0; i < 32; i++) begin
        src_i = 32'h1 << i;
        settle();
        check_all("R5");
      end
      src_i = 32'h8421_0F30; settle(); check_all("R10 multi");
      src_i = 32'hFFFF_FFFF; settle(); check_all("R10 full");
    end

    // R4 master off
    wr(8'h38, 32'h8000_0000); m_en[31] = 1'b0;
    src_i = 32'h7FFF_FFFF; settle(); check_all("R4");
    rd(8'h34, v); check("R4 enable", v, 32'h7FFF_FFFF);
    wr(8'h34, 32'h8000_0000); m_en[31] = 1'b1;

    // R3 partial and full clear
    wr(8'h38, 32'h0000_FFFF); m_en &= ~32'h0000_FFFF;
    rd(8'h34, v); check("R3 partial", v, m_en);
    settle(); check_all("R3");
    wr(8'h38, 32'hFFFF_FFFF); m_en = '0;
    rd(8'h34, v); check("R3 all", v, 32'h0);
    settle(); check_all("R3 off");

    // R9 writes to read-only offsets
    wr(8'h34, 32'h1234_5678); m_en = 32'h1234_5678;
    wr(8'h20, 32'h0F0F_0F0F); m_rt = 32'h0F0F_0F0F;
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF); wr(8'h30, 32'h0);
    rd(8'h34, v); check("R9 enable", v, m_en);
    rd(8'h20, v); check("R9 route", v, m_rt);

    // R8 and R7 timing: enable source 3 on line 0
    wr(8'h38, 32'hFFFF_FFFF); wr(8'h34, 32'h8000_0008); m_en = 32'h8000_0008;
    wr(8'h20, 32'h0); m_rt = '0;
    src_i = 32'h0; settle();
    @(negedge clk); src_i = 32'h8;
    repeat (2) @(negedge clk);
    rd(8'h00, v); check("R8 stat0 at 2", v, 32'h8);
    check("R8 irq0 not yet", {31'd0, irq0_o}, 32'h0);
    @(negedge clk);
    check("R8 irq0 at 3", {31'd0, irq0_o}, 32'h1);
    src_i = 32'h0;
    repeat (2) @(negedge clk);
    rd(8'h00, v); check("R7 drop stat0", v, 32'h0);
    check("R7 vld", {31'd0, first_vld_o}, 32'h0);
    @(negedge clk);
    check("R7 irq0 low", {31'd0, irq0_o}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule